// File: doc/BRIEF.md
# Per-Cycle Processor Clock Rate Switcher

This block generates the processor's double-rate clock from a single fast source clock. Each bus cycle either gets the undivided source clock or a slow clock that a free-running counter divides down from it. Slow is the default. A cycle moves the processor to the fast rate only when it is a memory cycle that falls outside a configurable slow-memory window.

The decision is taken on the source clock edge where the address strobe is seen active. It uses the address, the memory/IO flag and the interrupt-acknowledge indication. The chosen rate is then handed to the output through two enable flags that change only on the falling edge of the source clock. The old clock is always released before the new one is admitted. The slow clock is admitted or released only while it is low. As a result, neither level of the output is ever shorter than half a source period.

A status flag reports when the fast clock has taken over the output.

Top module: `cpu_clk_switch`

## Requirements
- R1: While reset is high, `cpu_clk` stays low and `fast_active` is 0; after reset the output runs at the slow rate.
- R2: In slow mode the `cpu_clk` period is 4 source periods when `div_sel` is 0 and 8 source periods when `div_sel` is 1.
- R3: A change of `div_sel` takes effect only when the divider counter wraps to zero, so it never shortens a slow-clock phase.
- R4: A strobed memory cycle (`mem_cycle`=1, `intr_ack`=0) whose address lies outside the window moves the output to the source period, and `fast_active` then reads 1.
- R5: A strobed I/O cycle (`mem_cycle`=0) returns the output to the slow rate with `fast_active` 0.
- R6: A strobed cycle with `intr_ack`=1 uses the slow rate even when `mem_cycle` is 1 and the address is outside the window.
- R7: A strobed memory cycle with `(addr & win_mask) == (win_base & win_mask)` uses the slow rate.
- R8: While `addr_strobe` is 0, the values on `addr`, `mem_cycle` and `intr_ack` have no effect on the rate.
- R9: No high or low phase of `cpu_clk` is shorter than half a source clock period, including across every rate change.
- R10: The fast and slow enables are never both set, `fast_active` is 1 only while the fast clock alone drives the output, and the slow enable changes only while the slow clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fast_clk | input | 1 | Source clock |
| rst | input | 1 | Asynchronous reset, active high |
| addr_strobe | input | 1 | Address strobe, active high, sampled on the rising source edge |
| addr | input | ADDR_W | Cycle address |
| mem_cycle | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| intr_ack | input | 1 | 1 = interrupt-acknowledge cycle |
| win_base | input | ADDR_W | Base of the slow memory window |
| win_mask | input | ADDR_W | Address bits compared for the window match |
| div_sel | input | 1 | Slow divisor: 0 = divide by 4, 1 = divide by 8 |
| cpu_clk | output | 1 | Selected processor clock |
| fast_active | output | 1 | 1 when the fast clock drives `cpu_clk` |

## Verification
The checker assumes that the strobe and the cycle-type inputs are synchronous to the rising edge of the source clock. It also assumes that the window configuration and `div_sel` never change in the same cycle as a strobe. The bench drives every input two nanoseconds after a rising source edge, and it changes `div_sel` and the window registers only while the strobe is low. Reset is held from time zero across several source periods, so the enables and the divider start from known values before any property is evaluated.

// File: rtl/clk_sw_pkg.sv
package clk_sw_pkg;

   typedef enum logic [1:0] {
      HS_SLOW    = 2'd0,
      HS_TO_FAST = 2'd1,
      HS_FAST    = 2'd2,
      HS_TO_SLOW = 2'd3
   } hand_state_t;

endpackage

// File: rtl/rate_divider.sv
module rate_divider #(
   parameter int LOG_A = 2,
   parameter int LOG_B = 3
) (
   input  logic fast_clk,
   input  logic rst,
   input  logic div_sel,
   output logic slow_q
);
   localparam int CW = (LOG_A > LOG_B) ? LOG_A : LOG_B;

   generate
      if (LOG_A < 1 || LOG_B < 1) begin : g_bad_log
         $error("rate_divider: divisor exponents must be at least 1");
      end
      if (LOG_A == LOG_B) begin : g_same_log
         $error("rate_divider: the two divisors must differ");
      end
   endgenerate

   logic [CW-1:0] cnt;
   logic [CW-1:0] cnt_n;
   logic          sel_q;
   logic          sel_n;
   logic          wrap;

   assign cnt_n = cnt + 1'b1;
   assign wrap  = (cnt == {CW{1'b1}});
   assign sel_n = wrap ? div_sel : sel_q;

   always_ff @(posedge fast_clk or posedge rst) begin
      if (rst) begin
         cnt    <= '0;
         sel_q  <= 1'b0;
         slow_q <= 1'b0;
      end else begin
         cnt    <= cnt_n;
         sel_q  <= sel_n;
         slow_q <= sel_n ? cnt_n[LOG_B-1] : cnt_n[LOG_A-1];
      end
   end
endmodule

// File: rtl/speed_decode.sv
module speed_decode #(
   parameter int ADDR_W = 24
) (
   input  logic              fast_clk,
   input  logic              rst,
   input  logic              addr_strobe,
   input  logic [ADDR_W-1:0] addr,
   input  logic              mem_cycle,
   input  logic              intr_ack,
   input  logic [ADDR_W-1:0] win_base,
   input  logic [ADDR_W-1:0] win_mask,
   output logic              want_fast
);
   generate
      if (ADDR_W < 2) begin : g_bad_aw
         $error("speed_decode: address width too small");
      end
   endgenerate

   logic in_window;
   logic pick_fast;

   assign in_window = ((addr ^ win_base) & win_mask) == '0;
   assign pick_fast = mem_cycle & ~intr_ack & ~in_window;

   always_ff @(posedge fast_clk or posedge rst) begin
      if (rst)
         want_fast <= 1'b0;
      else if (addr_strobe)
         want_fast <= pick_fast;
   end
endmodule

// File: rtl/clk_handover.sv
module clk_handover
   import clk_sw_pkg::*;
(
   input  logic fast_clk,
   input  logic rst,
   input  logic want_fast,
   input  logic slow_q,
   output logic en_fast,
   output logic en_slow,
   output logic cpu_clk,
   output logic fast_active
);
   hand_state_t st;
   logic        want_q;

   always_ff @(negedge fast_clk or posedge rst) begin
      if (rst) begin
         want_q  <= 1'b0;
         st      <= HS_TO_SLOW;
         en_fast <= 1'b0;
         en_slow <= 1'b0;
      end else begin
         want_q <= want_fast;
         case (st)
            HS_SLOW: begin
               if (want_q && !slow_q) begin
                  en_slow <= 1'b0;
                  st      <= HS_TO_FAST;
               end
            end
            HS_TO_FAST: begin
               en_fast <= 1'b1;
               st      <= HS_FAST;
            end
            HS_FAST: begin
               if (!want_q) begin
                  en_fast <= 1'b0;
                  st      <= HS_TO_SLOW;
               end
            end
            default: begin
               if (!slow_q) begin
                  en_slow <= 1'b1;
                  st      <= HS_SLOW;
               end
            end
         endcase
      end
   end

   assign cpu_clk     = (fast_clk & en_fast) | (slow_q & en_slow);
   assign fast_active = (st == HS_FAST);
endmodule

// File: rtl/cpu_clk_switch.sv
module cpu_clk_switch #(
   parameter int ADDR_W = 24,
   parameter int LOG_A  = 2,
   parameter int LOG_B  = 3
) (
   input  logic              fast_clk,
   input  logic              rst,
   input  logic              addr_strobe,
   input  logic [ADDR_W-1:0] addr,
   input  logic              mem_cycle,
   input  logic              intr_ack,
   input  logic [ADDR_W-1:0] win_base,
   input  logic [ADDR_W-1:0] win_mask,
   input  logic              div_sel,
   output logic              cpu_clk,
   output logic              fast_active
);
   logic want_fast;
   logic slow_q;
   logic en_fast;
   logic en_slow;

   speed_decode #(.ADDR_W(ADDR_W)) u_dec (
      .fast_clk    (fast_clk),
      .rst         (rst),
      .addr_strobe (addr_strobe),
      .addr        (addr),
      .mem_cycle   (mem_cycle),
      .intr_ack    (intr_ack),
      .win_base    (win_base),
      .win_mask    (win_mask),
      .want_fast   (want_fast)
   );

   rate_divider #(.LOG_A(LOG_A), .LOG_B(LOG_B)) u_div (
      .fast_clk (fast_clk),
      .rst      (rst),
      .div_sel  (div_sel),
      .slow_q   (slow_q)
   );

   clk_handover u_hand (
      .fast_clk    (fast_clk),
      .rst         (rst),
      .want_fast   (want_fast),
      .slow_q      (slow_q),
      .en_fast     (en_fast),
      .en_slow     (en_slow),
      .cpu_clk     (cpu_clk),
      .fast_active (fast_active)
   );
endmodule

// File: rtl/cpu_clk_switch_chk.sv
module cpu_clk_switch_chk #(
   parameter int ADDR_W = 24
) (
   input logic              fast_clk,
   input logic              rst,
   input logic              addr_strobe,
   input logic [ADDR_W-1:0] addr,
   input logic              mem_cycle,
   input logic              intr_ack,
   input logic [ADDR_W-1:0] win_base,
   input logic [ADDR_W-1:0] win_mask,
   input logic              want_fast,
   input logic              slow_q,
   input logic              en_fast,
   input logic              en_slow,
   input logic              cpu_clk,
   input logic              fast_active
);
   logic hit_win;
   assign hit_win = ((addr & win_mask) == (win_base & win_mask));

   AST_RST_CLK_LOW: assert property (@(negedge fast_clk) rst |-> (!cpu_clk && !fast_active)); // R1
   AST_IO_SLOW: assert property (@(posedge fast_clk) disable iff (rst)
      (addr_strobe && !mem_cycle) |=> !want_fast); // R5
   AST_INTA_SLOW: assert property (@(posedge fast_clk) disable iff (rst)
      (addr_strobe && intr_ack) |=> !want_fast); // R6
   AST_WIN_SLOW: assert property (@(posedge fast_clk) disable iff (rst)
      (addr_strobe && hit_win) |=> !want_fast); // R7
   AST_OUTSIDE_FAST: assert property (@(posedge fast_clk) disable iff (rst)
      (addr_strobe && mem_cycle && !intr_ack && !hit_win) |=> want_fast); // R4
   AST_NO_STROBE_HOLD: assert property (@(posedge fast_clk) disable iff (rst)
      !addr_strobe |=> $stable(want_fast)); // R8
   AST_ENABLES_EXCL: assert property (@(negedge fast_clk) disable iff (rst)
      !(en_fast && en_slow)); // R10
   AST_STATUS_MATCH: assert property (@(negedge fast_clk) disable iff (rst)
      fast_active |-> (en_fast && !en_slow)); // R10
   AST_SLOW_ON_LOW: assert property (@(negedge fast_clk) disable iff (rst)
      $rose(en_slow) |-> !$past(slow_q)); // R9
   AST_SLOW_OFF_LOW: assert property (@(negedge fast_clk) disable iff (rst)
      $fell(en_slow) |-> !$past(slow_q)); // R9
endmodule

bind cpu_clk_switch cpu_clk_switch_chk #(.ADDR_W(ADDR_W)) u_chk (
   .fast_clk    (fast_clk),
   .rst         (rst),
   .addr_strobe (addr_strobe),
   .addr        (addr),
   .mem_cycle   (mem_cycle),
   .intr_ack    (intr_ack),
   .win_base    (win_base),
   .win_mask    (win_mask),
   .want_fast   (want_fast),
   .slow_q      (slow_q),
   .en_fast     (en_fast),
   .en_slow     (en_slow),
   .cpu_clk     (cpu_clk),
   .fast_active (fast_active)
);

// File: tb/sim_cpu_clk_switch.sv
`timescale 1ns/1ps
module sim_cpu_clk_switch;
   localparam int AW = 24;

   logic          fast_clk = 1'b0;
   logic          rst = 1'b1;
   logic          addr_strobe = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          mem_cycle = 1'b0;
   logic          intr_ack = 1'b0;
   logic [AW-1:0] win_base = 24'h010000;
   logic [AW-1:0] win_mask = 24'hFF0000;
   logic          div_sel = 1'b0;
   logic          cpu_clk;
   logic          fast_active;

   int  n_run = 0;
   int  n_fail = 0;
   int  n_runt = 0;
   bit  done = 1'b0;
   real last_edge = -1.0;

   always #5 fast_clk = ~fast_clk;

   cpu_clk_switch #(.ADDR_W(AW)) u0 (
      .fast_clk(fast_clk), .rst(rst), .addr_strobe(addr_strobe), .addr(addr),
      .mem_cycle(mem_cycle), .intr_ack(intr_ack), .win_base(win_base),
      .win_mask(win_mask), .div_sel(div_sel), .cpu_clk(cpu_clk),
      .fast_active(fast_active)
   );

   // R9: measure every level of the output clock
   always @(posedge cpu_clk or negedge cpu_clk) begin
      if (!rst && last_edge >= 0.0 && ($realtime - last_edge) < 4.99)
         n_runt++;
      last_edge = $realtime;
   end

   task automatic chk_bit(input string req, input logic act, input logic exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0b expected %0b", req, act, exp);
      end
   endtask

   task automatic chk_period(input string req, input real exp);
      real t0, t1;
      @(posedge cpu_clk); t0 = $realtime;
      @(posedge cpu_clk); t1 = $realtime;
      n_run++;
      if ((t1 - t0) < exp - 0.01 || (t1 - t0) > exp + 0.01) begin
         n_fail++;
         $display("FAIL %s: period %0.2f ns expected %0.2f ns", req, t1 - t0, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      for (int i = 0; i < n; i++) @(posedge fast_clk);
      #2;
   endtask

   task automatic bus_cycle(input logic [AW-1:0] a, input logic mem, input logic ia);
      @(posedge fast_clk); #2;
      addr = a; mem_cycle = mem; intr_ack = ia; addr_strobe = 1'b1;
      @(posedge fast_clk); #2;
      addr_strobe = 1'b0;
   endtask

   task automatic t_reset();
      logic seen_high = 1'b0;
      for (int i = 0; i < 12; i++) begin
         @(posedge fast_clk); #1;
         if (cpu_clk) seen_high = 1'b1;
         #5;
         if (cpu_clk) seen_high = 1'b1;
      end
      chk_bit("R1 clock low in reset", seen_high, 1'b0);
      chk_bit("R1 status in reset", fast_active, 1'b0);
      @(posedge fast_clk); #2; rst = 1'b0;
      wait_cyc(20);
      chk_bit("R1 slow after reset", fast_active, 1'b0);
      chk_period("R2 divide by 4", 40.0);
   endtask

   task automatic t_go_fast(input string req);
      bus_cycle(24'h200000, 1'b1, 1'b0);
      wait_cyc(40);
      chk_bit({req, " status"}, fast_active, 1'b1);
      chk_period({req, " period"}, 10.0);
   endtask

   task automatic t_slow_by(input string req, input logic [AW-1:0] a,
                            input logic mem, input logic ia, input real per);
      bus_cycle(a, mem, ia);
      wait_cyc(40);
      chk_bit({req, " status"}, fast_active, 1'b0);
      chk_period({req, " period"}, per);
   endtask

   task automatic t_no_strobe();
      @(posedge fast_clk); #2;
      addr = 24'h010010; mem_cycle = 1'b0; intr_ack = 1'b1;
      wait_cyc(40);
      chk_bit("R8 status without strobe", fast_active, 1'b1);
      chk_period("R8 period without strobe", 10.0);
   endtask

   task automatic t_div8();
      @(posedge fast_clk); #2; div_sel = 1'b1;
      wait_cyc(30);
      chk_period("R3 divisor applied after wrap", 80.0);
      chk_period("R2 divide by 8", 80.0);
   endtask

   initial begin
      t_reset();
      t_go_fast("R4 outside window");
      t_slow_by("R5 io cycle", 24'h200000, 1'b0, 1'b0, 40.0);
      t_go_fast("R4 again");
      t_slow_by("R6 interrupt ack", 24'h300000, 1'b1, 1'b1, 40.0);
      t_go_fast("R4 before window");
      t_slow_by("R7 window hit", 24'h01ABCD, 1'b1, 1'b0, 40.0);
      t_go_fast("R4 before no-strobe");
      t_no_strobe();
      t_slow_by("R5 io to slow", 24'h000010, 1'b0, 1'b0, 40.0);
      t_div8();
      t_go_fast("R4 from divide by 8");
      t_slow_by("R7 window at divide by 8", 24'h01FFFF, 1'b1, 1'b0, 80.0);
      for (int k = 0; k < 5; k++) begin
         wait_cyc(k);
         bus_cycle(24'h400000, 1'b1, 1'b0);
         wait_cyc(3 + k);
         bus_cycle(24'h000001, 1'b0, 1'b0);
      end
      wait_cyc(60);
      n_run++;
      if (n_runt != 0) begin
         n_fail++;
         $display("FAIL R9 short clock phases: got %0d expected 0", n_runt);
      end
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #1500000;
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule